// File: doc/BRIEF.md
# Keyed Configuration Space Controller

This block guards the configuration registers of a multi-function I/O chip behind a two-write unlock sequence on a host I/O bus. The bus reaches the block through two byte-wide ports: an index port (port select 0) and a data port (port select 1, one address above the index port). While the space is locked, no register can be reached. Writing the key byte to the index port twice in a row opens the space. After that, index-port writes choose a register number, and data-port accesses read or write that register. A dedicated exit byte written to the index port locks the space again.

The block holds three configuration registers and drives their fields straight out to the rest of the chip:

- Register 0x01: parallel base-address select, port power, standard-only mode and interrupt polarity.
- Register 0x04: extended-mode select and EPP protocol version.
- Register 0x0A: ECP FIFO service threshold.

A parameter picks one of two chip variants, and the variant sets the key byte. Reads are combinational. `io_rdata` is valid in the same cycle as `io_rd` and is zero whenever `io_rd` is low. The register bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `cfgkey_ctrl`

## Requirements
- R1: After reset the space is locked (`cfg_open`=0) and the exports take these values: `par_base_sel`=2'b11, `par_power`=1, `spp_only`=1, `irq_act_high`=1, `ext_mode`=2'b00, `epp_legacy`=0, `fifo_thresh`=0.
- R2: Two consecutive index-port writes of the key byte open the space, with `cfg_open` high from the cycle after the second write. The key is 0x55 when `ALT_VARIANT`=0 and 0x44 when `ALT_VARIANT`=1.
- R3: If exactly one key has been seen, any other index-port write (including 0xAA) returns the block to locked. Data-port accesses between the two key writes do not disturb the sequence.
- R4: While the space is not open, data-port writes are ignored, and reads of either port return 0xFF. Whenever `io_rd` is low, `io_rdata` is 0x00.
- R5: While open, an index-port write of any byte other than 0xAA selects that register number. An index-port read returns the selected number, and data-port reads and writes act on the selected register.
- R6: Register 0x01 is laid out as follows: bits 1:0 drive `par_base_sel` (00 disabled, 01 0x3BC, 10 0x378, 11 0x278); bit 2 drives `par_power`; bit 3 drives `spp_only`; bit 4 drives `irq_act_high`. Its reset value reads as 0x1F.
- R7: In register 0x04, bits 1:0 drive `ext_mode` and bit 6 drives `epp_legacy`. Its reset value reads as 0x00.
- R8: In register 0x0A, bits 3:0 drive `fifo_thresh`. Its reset value reads as 0x00.
- R9: Writes to unimplemented register numbers are ignored, and those numbers read as 0x00. Unimplemented bits of the three registers read as 0: the readable masks are 0x1F, 0x43 and 0x0F.
- R10: While open, an index-port write of 0xAA locks the space and clears the selected number to 0x00. While locked, a 0xAA write has no effect.
- R11: The exports change only in the cycle after a data-port write made while the space is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_port | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational |
| cfg_open | output | 1 | High while the configuration space is unlocked |
| par_base_sel | output | 2 | Parallel port base-address select |
| par_power | output | 1 | Parallel port power enable |
| spp_only | output | 1 | 1 restricts the port to standard mode |
| irq_act_high | output | 1 | Interrupt polarity, 1 means active high |
| ext_mode | output | 2 | Extended-mode select |
| epp_legacy | output | 1 | 1 selects the older EPP protocol version |
| fifo_thresh | output | 4 | ECP FIFO service threshold |

## Verification
A wrong unlock state shows up at once at the ports. `cfg_open` moves one cycle after the deciding index write, and a data-port read in that same cycle returns 0xFF where the selected register's value was expected, or the reverse. A corrupted register or a stray write shows up on the export pins in the cycle after the bad write. A wrong selected number is caught on the next index-port read. The mixed random traffic is biased toward key bytes, the exit byte and the implemented register numbers, so that the armed-state relock paths and the masked bits are reached often.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

  localparam int BYTE_W = 8;
  localparam int NREG   = 3;

  localparam logic [BYTE_W-1:0] KEY_MAIN = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_ALT  = 8'h44;
  localparam logic [BYTE_W-1:0] EXIT_KEY = 8'hAA;
  localparam logic [BYTE_W-1:0] LOCK_RD  = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } unlock_st_t;

  typedef logic [NREG-1:0][BYTE_W-1:0] reg_bank_t;

  function automatic logic [BYTE_W-1:0] key_for(input bit alt);
    return alt ? KEY_ALT : KEY_MAIN;
  endfunction

  // Slot table: register number, writable/readable mask, reset value.
  function automatic logic [BYTE_W-1:0] slot_num(input int i);
    case (i)
      0:       return 8'h01;
      1:       return 8'h04;
      default: return 8'h0A;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] slot_mask(input int i);
    case (i)
      0:       return 8'h1F;
      1:       return 8'h43;
      default: return 8'h0F;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] slot_dflt(input int i);
    case (i)
      0:       return 8'h1F;
      1:       return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgkey_unlock.sv
module cfgkey_unlock
  import cfgkey_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic              open,
  output logic [BYTE_W-1:0] sel_idx
);

  localparam logic [BYTE_W-1:0] KEY = key_for(ALT_VARIANT);

  unlock_st_t st_q, st_d;
  logic [BYTE_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (idx_we) begin
      unique case (st_q)
        ST_LOCKED: if (wdata == KEY) st_d = ST_ARMED;
        ST_ARMED:  st_d = (wdata == KEY) ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (wdata == EXIT_KEY) begin
            st_d  = ST_LOCKED;
            idx_d = '0;
          end else begin
            idx_d = wdata;
          end
        end
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_LOCKED;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign open    = (st_q == ST_OPEN);
  assign sel_idx = idx_q;

endmodule

// File: rtl/cfgkey_regfile.sv
module cfgkey_regfile
  import cfgkey_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] sel_idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] sel_val,
  output reg_bank_t         bank
);

  logic [NREG-1:0]             hit;
  logic [NREG-1:0][BYTE_W-1:0] masked;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [BYTE_W-1:0] NUM  = slot_num(g);
    localparam logic [BYTE_W-1:0] MASK = slot_mask(g);
    localparam logic [BYTE_W-1:0] DFLT = slot_dflt(g);

    logic [BYTE_W-1:0] val_q;

    assign hit[g] = (sel_idx == NUM);

    always_ff @(posedge clk) begin
      if (!rst_n)              val_q <= DFLT;
      else if (we && hit[g])   val_q <= wdata & MASK;
    end

    assign bank[g]   = val_q;
    assign masked[g] = hit[g] ? val_q : '0;
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NREG; i++) sel_val = sel_val | masked[i];
  end

endmodule

// File: rtl/cfgkey_ctrl.sv
module cfgkey_ctrl
  import cfgkey_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic       io_port,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cfg_open,
  output logic [1:0] par_base_sel,
  output logic       par_power,
  output logic       spp_only,
  output logic       irq_act_high,
  output logic [1:0] ext_mode,
  output logic       epp_legacy,
  output logic [3:0] fifo_thresh
);

  logic              open;
  logic [BYTE_W-1:0] sel_idx;
  logic [BYTE_W-1:0] sel_val;
  reg_bank_t         bank;

  cfgkey_unlock #(.ALT_VARIANT(ALT_VARIANT)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_we  (io_wr && !io_port),
    .wdata   (io_wdata),
    .open    (open),
    .sel_idx (sel_idx)
  );

  cfgkey_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (io_wr && io_port && open),
    .sel_idx (sel_idx),
    .wdata   (io_wdata),
    .sel_val (sel_val),
    .bank    (bank)
  );

  always_comb begin
    if (!io_rd)        io_rdata = '0;
    else if (!open)    io_rdata = LOCK_RD;
    else if (io_port)  io_rdata = sel_val;
    else               io_rdata = sel_idx;
  end

  assign cfg_open     = open;
  assign par_base_sel = bank[0][1:0];
  assign par_power    = bank[0][2];
  assign spp_only     = bank[0][3];
  assign irq_act_high = bank[0][4];
  assign ext_mode     = bank[1][1:0];
  assign epp_legacy   = bank[1][6];
  assign fifo_thresh  = bank[2][3:0];

endmodule

// File: rtl/cfgkey_ctrl_chk.sv
module cfgkey_ctrl_chk
  import cfgkey_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic       io_rd,
  input logic       io_port,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       cfg_open,
  input logic [1:0] par_base_sel,
  input logic       par_power,
  input logic       spp_only,
  input logic       irq_act_high,
  input logic [1:0] ext_mode,
  input logic       epp_legacy,
  input logic [3:0] fifo_thresh
);

  localparam logic [7:0] KEY = key_for(ALT_VARIANT);

  logic [12:0] exports;
  assign exports = {par_base_sel, par_power, spp_only, irq_act_high,
                    ext_mode, epp_legacy, fifo_thresh};

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && !io_port && io_wdata == KEY));

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> io_rdata == LOCK_RD);

  // R4
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

  // R10
  exit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && !io_port && io_wdata == EXIT_KEY) |=> !cfg_open);

  // R11
  export_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_open && io_wr && io_port) |=> $stable(exports));

  // R3
  data_no_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && !(io_wr && !io_port)) |=> !cfg_open);

endmodule

bind cfgkey_ctrl cfgkey_ctrl_chk #(.ALT_VARIANT(ALT_VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
  .par_base_sel(par_base_sel), .par_power(par_power), .spp_only(spp_only),
  .irq_act_high(irq_act_high), .ext_mode(ext_mode), .epp_legacy(epp_legacy),
  .fifo_thresh(fifo_thresh)
);

// File: tb/cfgkey_ctrl_test.sv
module cfgkey_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_port = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, a_rdata;
  logic       cfg_open, a_open;
  logic [1:0] par_base_sel, ext_mode, a_bs, a_em;
  logic       par_power, spp_only, irq_act_high, epp_legacy;
  logic       a_pp, a_so, a_ih, a_el;
  logic [3:0] fifo_thresh, a_ft;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgkey_ctrl uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .par_base_sel(par_base_sel), .par_power(par_power), .spp_only(spp_only),
    .irq_act_high(irq_act_high), .ext_mode(ext_mode), .epp_legacy(epp_legacy),
    .fifo_thresh(fifo_thresh));

  cfgkey_ctrl #(.ALT_VARIANT(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(a_rdata), .cfg_open(a_open),
    .par_base_sel(a_bs), .par_power(a_pp), .spp_only(a_so),
    .irq_act_high(a_ih), .ext_mode(a_em), .epp_legacy(a_el), .fifo_thresh(a_ft));

  localparam logic [7:0] KEY = 8'h55;

  // Reference model: 0 locked, 1 armed, 2 open
  int         m_st  = 0;
  logic [7:0] m_idx = 8'h00;
  logic [7:0] m_r1 = 8'h1F, m_r4 = 8'h00, m_ra = 8'h00;

  function automatic logic [7:0] exp_read(input logic port);
    if (m_st != 2) return 8'hFF;
    if (!port)     return m_idx;
    case (m_idx)
      8'h01:   return m_r1;
      8'h04:   return m_r4;
      8'h0A:   return m_ra;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [12:0] exp_exports();
    return {m_r1[1:0], m_r1[2], m_r1[3], m_r1[4], m_r4[1:0], m_r4[6], m_ra[3:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic port, input logic [7:0] d);
    if (!port) begin
      case (m_st)
        0: if (d == KEY) m_st = 1;
        1: m_st = (d == KEY) ? 2 : 0;
        default: if (d == 8'hAA) begin m_st = 0; m_idx = 8'h00; end
                 else m_idx = d;
      endcase
    end else if (m_st == 2) begin
      case (m_idx)
        8'h01: m_r1 = d & 8'h1F;
        8'h04: m_r4 = d & 8'h43;
        8'h0A: m_ra = d & 8'h0F;
        default: ;
      endcase
    end
  endtask

  task automatic do_wr(input logic port, input logic [7:0] d);
    io_port = port; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(port, d);
  endtask

  task automatic do_rd(input logic port, input string req);
    io_port = port; io_rd = 1'b1;
    #1;
    check(req, io_rdata, exp_read(port));
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic check_state(input string req);
    #1;
    check(req, cfg_open, m_st == 2);
    check(req, {par_base_sel, par_power, spp_only, irq_act_high,
                ext_mode, epp_legacy, fifo_thresh}, exp_exports());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");
    check("R1 idle rdata", io_rdata, 8'h00);

    // R4 locked reads and ignored writes
    do_rd(1'b1, "R4 locked data read");
    do_rd(1'b0, "R4 locked index read");
    do_wr(1'b1, 8'h00); check_state("R4 locked data write");
    // R10 exit byte while locked
    do_wr(1'b0, 8'hAA); check_state("R10 AA locked");

    // R2 variant keys: 0x55 twice opens main only
    do_wr(1'b0, 8'h55); do_wr(1'b0, 8'h55); #1;
    check("R2 main open", cfg_open, 1'b1);
    check("R2 alt stays locked", a_open, 1'b0);
    @(negedge clk);
    do_wr(1'b0, 8'hAA);
    do_wr(1'b0, 8'h44); do_wr(1'b0, 8'h44); #1;
    check("R2 alt open", a_open, 1'b1);
    check("R2 main stays locked", cfg_open, 1'b0);
    @(negedge clk);
    do_wr(1'b0, 8'hAA);

    // R3 key, non-key, key: stays locked; data access between keys harmless
    do_wr(1'b0, KEY); do_wr(1'b0, 8'h01); do_wr(1'b0, KEY); check_state("R3 relock");
    do_wr(1'b0, KEY);  // second key after the first one: opens
    check_state("R3 second key");
    do_wr(1'b0, 8'hAA);
    do_wr(1'b0, KEY); do_wr(1'b0, 8'hAA); do_wr(1'b0, KEY); check_state("R3 AA when armed");
    do_wr(1'b0, 8'hAA);
    do_wr(1'b0, KEY); do_wr(1'b1, 8'h3C); do_rd(1'b1, "R3 read while armed");
    do_wr(1'b0, KEY); check_state("R3 data between keys");

    // R5/R6 select and access register 1
    do_wr(1'b0, 8'h01); do_rd(1'b0, "R5 index readback");
    do_rd(1'b1, "R6 reg1 default");
    do_wr(1'b1, 8'hE2); check_state("R6 reg1 write");
    do_rd(1'b1, "R9 reg1 masked bits");
    // R7
    do_wr(1'b0, 8'h04); do_wr(1'b1, 8'hFF); check_state("R7 reg4 write");
    do_rd(1'b1, "R7 reg4 read 0x43");
    // R8
    do_wr(1'b0, 8'h0A); do_wr(1'b1, 8'hF9); check_state("R8 regA write");
    do_rd(1'b1, "R8 regA read");
    // R9 unimplemented
    do_wr(1'b0, 8'h02); do_wr(1'b1, 8'h77); check_state("R9 unimpl write");
    do_rd(1'b1, "R9 unimpl read");
    // R10 exit clears index
    do_wr(1'b0, 8'hAA); check_state("R10 exit");
    do_wr(1'b0, KEY); do_wr(1'b0, KEY);
    do_rd(1'b0, "R10 index cleared");

    // Random mix (R5, R11 and all above)
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [7:0] v;
      r = $urandom % 10;
      if (r < 4) begin
        case ($urandom % 7)
          0, 1:    v = KEY;
          2:       v = 8'hAA;
          3:       v = 8'h01;
          4:       v = 8'h04;
          5:       v = 8'h0A;
          default: v = 8'($urandom);
        endcase
        do_wr(1'b0, v);
        check_state("R11 random index write");
      end else if (r < 7) begin
        do_wr(1'b1, 8'($urandom));
        check_state("R11 random data write");
      end else begin
        do_rd(1'($urandom), "R5 random read");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule